// File: doc/BRIEF.md
# Two-Wire DAC Code and Power Slave

This block is the digital front end of a small voltage-output DAC. It listens on a two-wire (I2C-compatible) bus as a receive-only target. It holds the converter's 8-bit code register and its power-down flag. A fast system clock oversamples the SCL and SDA pins. Each pin passes through a two-flop synchronizer and then a stable-count filter. A state machine then decodes START, repeated START, STOP and the data bits. The device answers to one of four 7-bit addresses, chosen by a two-bit strap. The last bit of the address byte is not a read/write flag: it is a power-down request. A 0 there means the master writes a code byte. A 1 means the master clocks a byte out, and the block leaves SDA released so that the master reads ones. The new code and power mode are held pending and take effect only when a STOP comes straight after that second byte.

The state machine has nine states. ST_IDLE waits for a START. ST_ADDR shifts in the address byte. From there the block goes to ST_ADDR_ACK on a match or to ST_SKIP on a miss. After the acknowledge it goes to ST_WDATA and then ST_WDATA_ACK for a write, or to ST_RDATA and then ST_RDATA_ACK for a power-down read. Both paths end in ST_HOLD. In ST_HOLD a STOP commits the pending update, and any further clock cancels it.

Global transitions take priority over the per-state ones. A START from any state goes to ST_ADDR and drops the pending update. A STOP from any state goes to ST_IDLE. Within a state, a bit is sampled on each filtered SCL rise, and the state advances on the SCL fall that ends the 8th bit or the acknowledge bit. The open-drain acknowledge appears as an active-high pull-low enable.

Top module: `dac_link_slave`

## Requirements
- R1: The block answers only the 7-bit address 0x30 plus the strap value (0 to 3). Left-justified, these are the bytes 0x60, 0x62, 0x64 and 0x66. The address is the first 7 bits after a START, MSB first.
- R2: On a matching address the block asserts sda_drive_low for the whole 9th SCL clock, whatever the value of bit 8. It asserts it at no other time except the data-byte acknowledge of a write.
- R3: Bit 8 of the address byte selects the transaction type. A 0 means a code write follows. A 1 means a power-down read follows.
- R4: An address byte followed directly by a STOP or a repeated START leaves code_full, code_eff and shutdown unchanged.
- R5: In a write, the second byte is taken MSB first and acknowledged. At the STOP that follows, code_full becomes that byte, and shutdown clears.
- R6: A repeated START after the second byte discards the pending update. A later STOP then changes nothing.
- R7: Non-matching addresses are not acknowledged and cause no update. This includes the general call 0x00 and the 10-bit prefix 11110xx.
- R8: In a power-down read, SDA stays released for all 8 data bits, so the master reads 0xFF. At the following STOP shutdown becomes 1, and code_full keeps its value.
- R9: After reset, code_full is 0, code_eff is 0, shutdown is 0 and sda_drive_low is 0.
- R10: code_eff equals code_full[7:2] while shutdown is 0, and equals 0 while shutdown is 1.
- R11: A committed write clears shutdown and loads the code in the same clock. code_eff shows the new code at once.
- R12: A byte clocked after the second byte is not acknowledged. A STOP after it changes nothing.
- R13: A pulse on SCL or SDA that lasts fewer than FILT_LEN system clocks is ignored by the bus logic.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | Bus clock pin level |
| sda_in | input | 1 | Bus data pin level |
| addr_sel | input | 2 | Address strap, added to 0x30 |
| sda_drive_low | output | 1 | Enable that pulls SDA low for an acknowledge |
| code_full | output | 8 | Committed code, 6 code bits then 2 sub-bits |
| code_eff | output | 6 | Effective code, zero during shutdown |
| shutdown | output | 1 | Committed power-down flag |

## Verification
One clock edge can both load a new code and clear the shutdown flag. This happens when a write with bit 8 at 0 reaches its STOP while the block is powered down. If the two registers were updated in separate steps, code_eff could briefly show zero or the stale code. The bench first commits a power-down read and checks that code_eff is forced to zero. It then commits a write and checks, in the sampling slot after the STOP, that shutdown is 0 and that code_eff already equals the upper six bits of the new byte.

// File: rtl/dls_pkg.sv
package dls_pkg;
    localparam int BYTE_BITS = 8;
    localparam int BIT_CNT_W = $clog2(BYTE_BITS + 1);

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_WDATA,
        ST_WDATA_ACK,
        ST_RDATA,
        ST_RDATA_ACK,
        ST_HOLD,
        ST_SKIP
    } bus_state_t;
endpackage

// File: rtl/dls_line_filter.sv
module dls_line_filter #(
    parameter int   FILT_LEN  = 3,
    parameter logic IDLE_LVL  = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    output logic level
);
    localparam int CW = $clog2(FILT_LEN + 1);

    logic          s1, s2;
    logic [CW-1:0] run_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1      <= IDLE_LVL;
            s2      <= IDLE_LVL;
            run_cnt <= '0;
            level   <= IDLE_LVL;
        end else begin
            s1 <= pin;
            s2 <= s1;
            if (s2 != level) begin
                if (run_cnt == CW'(FILT_LEN - 1)) begin
                    level   <= s2;
                    run_cnt <= '0;
                end else begin
                    run_cnt <= run_cnt + 1'b1;
                end
            end else begin
                run_cnt <= '0;
            end
        end
    end

    // R13: a new filtered level must have been present on the synchronized input
    assert_filter_follows_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (level != $past(level)) |-> ($past(s2) == level));
endmodule

// File: rtl/dls_bus_engine.sv
module dls_bus_engine
    import dls_pkg::*;
#(
    parameter logic [6:0] ADDR_BASE = 7'h30
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 scl,
    input  logic                 sda,
    input  logic [1:0]           addr_sel,
    output logic                 sda_low,
    output logic                 commit,
    output logic [BYTE_BITS-1:0] commit_code,
    output logic                 commit_shdn
);
    bus_state_t             state, nxt;
    logic                   scl_d, sda_d;
    logic [BIT_CNT_W-1:0]   bit_cnt;
    logic [BYTE_BITS-1:0]   shreg;
    logic                   shdn_req, pend_ok, addr_hit_q;
    logic                   start_det, stop_det, scl_rise, scl_fall, byte_end, ack_end, hit;
    logic [6:0]             my_addr;

    assign my_addr   = ADDR_BASE + {5'd0, addr_sel};
    assign start_det = scl & scl_d & sda_d & ~sda;
    assign stop_det  = scl & scl_d & ~sda_d & sda;
    assign scl_rise  = scl & ~scl_d;
    assign scl_fall  = ~scl & scl_d;
    assign byte_end  = scl_fall && (bit_cnt == BIT_CNT_W'(BYTE_BITS));
    assign ack_end   = scl_fall && (bit_cnt != '0);
    assign hit       = (shreg[BYTE_BITS-1:1] == my_addr);

    always_comb begin
        nxt = state;
        if (start_det) begin
            nxt = ST_ADDR;
        end else if (stop_det) begin
            nxt = ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE:      nxt = ST_IDLE;
                ST_ADDR:      if (byte_end) nxt = hit ? ST_ADDR_ACK : ST_SKIP;
                ST_ADDR_ACK:  if (ack_end)  nxt = shdn_req ? ST_RDATA : ST_WDATA;
                ST_WDATA:     if (byte_end) nxt = ST_WDATA_ACK;
                ST_WDATA_ACK: if (ack_end)  nxt = ST_HOLD;
                ST_RDATA:     if (byte_end) nxt = ST_RDATA_ACK;
                ST_RDATA_ACK: if (ack_end)  nxt = ST_HOLD;
                ST_HOLD:      nxt = ST_HOLD;
                ST_SKIP:      nxt = ST_SKIP;
                default:      nxt = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_d       <= 1'b1;
            sda_d       <= 1'b1;
            bit_cnt     <= '0;
            shreg       <= '0;
            shdn_req    <= 1'b0;
            pend_ok     <= 1'b0;
            addr_hit_q  <= 1'b0;
            sda_low     <= 1'b0;
            commit      <= 1'b0;
            commit_code <= '0;
        end else begin
            scl_d   <= scl;
            sda_d   <= sda;
            sda_low <= (nxt == ST_ADDR_ACK) || (nxt == ST_WDATA_ACK);
            commit  <= stop_det && (state == ST_HOLD) && pend_ok;

            if (nxt != state)  bit_cnt <= '0;
            else if (scl_rise) bit_cnt <= bit_cnt + 1'b1;

            if (scl_rise && (state == ST_ADDR || state == ST_WDATA))
                shreg <= {shreg[BYTE_BITS-2:0], sda};

            if (state == ST_ADDR && nxt == ST_ADDR_ACK) begin
                shdn_req   <= shreg[0];
                addr_hit_q <= 1'b1;
            end else if (start_det) begin
                addr_hit_q <= 1'b0;
            end

            if (state == ST_WDATA && nxt == ST_WDATA_ACK)
                commit_code <= shreg;

            if (start_det || stop_det)
                pend_ok <= 1'b0;
            else if ((state == ST_WDATA_ACK || state == ST_RDATA_ACK) && nxt == ST_HOLD)
                pend_ok <= 1'b1;
            else if (state == ST_HOLD && scl_fall)
                pend_ok <= 1'b0;
        end
    end

    assign commit_shdn = shdn_req;

    // R2: acknowledge only after a matching address
    assert_ack_needs_match_R2: assert property (@(posedge clk) disable iff (!rst_n)
        sda_low |-> addr_hit_q);
    // R8: SDA is left released through the power-down read byte
    assert_read_released_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RDATA || state == ST_RDATA_ACK) |-> !sda_low);
    // R5: a commit follows a STOP, so the machine is back in idle
    assert_commit_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        commit |-> (state == ST_IDLE));
endmodule

// File: rtl/dac_link_slave.sv
module dac_link_slave
    import dls_pkg::*;
#(
    parameter logic [6:0] ADDR_BASE = 7'h30,
    parameter int         FILT_LEN  = 3,
    parameter int         SUB_BITS  = 2
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            scl_in,
    input  logic                            sda_in,
    input  logic [1:0]                      addr_sel,
    output logic                            sda_drive_low,
    output logic [BYTE_BITS-1:0]            code_full,
    output logic [BYTE_BITS-SUB_BITS-1:0]   code_eff,
    output logic                            shutdown
);
    localparam int EFF_W = BYTE_BITS - SUB_BITS;

    logic [1:0]           pins, lines;
    logic                 commit_w, commit_shdn_w;
    logic [BYTE_BITS-1:0] commit_code_w;
    logic [BYTE_BITS-1:0] code_q;
    logic                 shdn_q;

    assign pins = {scl_in, sda_in};

    for (genvar g = 0; g < 2; g++) begin : g_line
        dls_line_filter #(.FILT_LEN(FILT_LEN), .IDLE_LVL(1'b1)) u_filt (
            .clk   (clk),
            .rst_n (rst_n),
            .pin   (pins[g]),
            .level (lines[g])
        );
    end

    dls_bus_engine #(.ADDR_BASE(ADDR_BASE)) u_engine (
        .clk         (clk),
        .rst_n       (rst_n),
        .scl         (lines[1]),
        .sda         (lines[0]),
        .addr_sel    (addr_sel),
        .sda_low     (sda_drive_low),
        .commit      (commit_w),
        .commit_code (commit_code_w),
        .commit_shdn (commit_shdn_w)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            code_q <= '0;
            shdn_q <= 1'b0;
        end else if (commit_w) begin
            shdn_q <= commit_shdn_w;
            if (!commit_shdn_w) code_q <= commit_code_w;
        end
    end

    assign code_full = code_q;
    assign shutdown  = shdn_q;
    assign code_eff  = shdn_q ? '0 : code_q[BYTE_BITS-1 -: EFF_W];

    // R4: without a commit pulse the code and power mode hold
    assert_hold_without_commit_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !commit_w |=> ($stable(code_q) && $stable(shdn_q)));
endmodule

// File: tb/dac_link_slave_tb.sv
module dac_link_slave_tb;
    localparam int CLK_PERIOD = 10;
    localparam int Q = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl_m = 1'b1;
    logic       sda_m = 1'b1;
    logic [1:0] addr_sel = 2'd0;
    logic       sda_drive_low;
    logic [7:0] code_full;
    logic [5:0] code_eff;
    logic       shutdown;
    logic       sda_line;

    int checks = 0;
    int errors = 0;
    logic [7:0] exp_code = 8'h00;
    logic       exp_shdn = 1'b0;

    assign sda_line = sda_m & ~sda_drive_low;

    always #(CLK_PERIOD/2) clk = ~clk;

    dac_link_slave u_dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .scl_in        (scl_m),
        .sda_in        (sda_line),
        .addr_sel      (addr_sel),
        .sda_drive_low (sda_drive_low),
        .code_full     (code_full),
        .code_eff      (code_eff),
        .shutdown      (shutdown)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input logic ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic bus_start();
        sda_m = 1'b1; tick(Q);
        scl_m = 1'b1; tick(Q);
        sda_m = 1'b0; tick(Q);
        scl_m = 1'b0; tick(Q);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; tick(Q);
        scl_m = 1'b1; tick(Q);
        sda_m = 1'b1; tick(2*Q);
    endtask

    task automatic bus_bit(input logic b, input logic glitch, output logic seen);
        sda_m = b;
        if (glitch) begin
            tick(2);
            scl_m = 1'b1; tick(2);
            scl_m = 1'b0; tick(Q-4);
        end else begin
            tick(Q);
        end
        scl_m = 1'b1; tick(Q);
        seen = sda_line;
        tick(Q);
        scl_m = 1'b0; tick(Q);
    endtask

    task automatic bus_byte(input logic [7:0] b, input logic glitch,
                            output logic acked, output logic [7:0] rd);
        logic s;
        for (int i = 7; i >= 0; i--) begin
            bus_bit(b[i], glitch && (i == 4), s);
            rd[i] = s;
        end
        bus_bit(1'b1, 1'b0, s);
        acked = ~s;
    endtask

    task automatic check_state(input string req);
        check(code_full == exp_code, req, code_full, exp_code);
        check(shutdown == exp_shdn, req, shutdown, exp_shdn);
        check(code_eff == (exp_shdn ? 6'd0 : exp_code[7:2]), req, code_eff,
              exp_shdn ? 0 : exp_code[7:2]);
    endtask

    task automatic do_write(input logic [6:0] a, input logic [7:0] v, input logic glitch,
                            output logic ack_a, output logic ack_d);
        logic [7:0] rd;
        bus_start();
        bus_byte({a, 1'b0}, 1'b0, ack_a, rd);
        bus_byte(v, glitch, ack_d, rd);
        bus_stop();
    endtask

    initial begin
        logic ka, kd;
        logic [7:0] rd;
        logic [6:0] me;
        rst_n = 1'b0;
        tick(5);
        rst_n = 1'b1;
        tick(4);
        // R9 reset state
        check(code_full == 8'h00, "R9", code_full, 0);
        check(code_eff == 6'd0, "R9", code_eff, 0);
        check(shutdown == 1'b0, "R9", shutdown, 0);
        check(sda_drive_low == 1'b0, "R9", sda_drive_low, 0);

        // R1 R2 R3 R4: address sweep over every strap, probes only
        for (int s = 0; s < 4; s++) begin
            addr_sel = 2'(s);
            tick(2);
            for (int a = 0; a < 4; a++) begin
                for (int sh = 0; sh < 2; sh++) begin
                    bus_start();
                    bus_byte({7'h30 + 7'(a), 1'(sh)}, 1'b0, ka, rd);
                    bus_stop();
                    check(ka == (a == s), "R1", ka, (a == s));
                    check(sda_drive_low == 1'b0, "R2", sda_drive_low, 0);
                end
            end
            check_state("R4");
        end

        addr_sel = 2'd2;
        me = 7'h32;
        tick(2);

        // R5 R10: write sweep with varied sub-bits
        for (int i = 0; i < 64; i++) begin
            logic [7:0] v;
            v = (8'(i) << 2) | 8'(i & 3);
            do_write(me, v, 1'b0, ka, kd);
            exp_code = v;
            check(ka && kd, "R5", {ka, kd}, 3);
            check_state("R5");
        end

        // R7: general call and 10-bit prefix
        do_write(7'h00, 8'h11, 1'b0, ka, kd);
        check(!ka, "R7", ka, 0);
        check_state("R7");
        do_write(7'h78, 8'h22, 1'b0, ka, kd);
        check(!ka, "R7", ka, 0);
        do_write(7'h31, 8'h33, 1'b0, ka, kd);
        check(!ka, "R7", ka, 0);
        check_state("R7");

        // R6: repeated START after data byte discards update
        bus_start();
        bus_byte({me, 1'b0}, 1'b0, ka, rd);
        bus_byte(8'h44, 1'b0, kd, rd);
        bus_start();
        bus_stop();
        check(kd, "R6", kd, 1);
        check_state("R6");

        // R4: repeated START right after address with power-down bit
        bus_start();
        bus_byte({me, 1'b1}, 1'b0, ka, rd);
        bus_start();
        bus_stop();
        check(ka, "R4", ka, 1);
        check_state("R4");

        // R12: third byte not acknowledged, no update
        bus_start();
        bus_byte({me, 1'b0}, 1'b0, ka, rd);
        bus_byte(8'h10, 1'b0, kd, rd);
        bus_byte(8'h20, 1'b0, ka, rd);
        bus_stop();
        check(kd, "R12", kd, 1);
        check(!ka, "R12", ka, 0);
        check_state("R12");

        // R8 R3 R10: power-down read
        bus_start();
        bus_byte({me, 1'b1}, 1'b0, ka, rd);
        bus_byte(8'hFF, 1'b0, kd, rd);
        check(ka, "R3", ka, 1);
        check(rd == 8'hFF, "R8", rd, 8'hFF);
        bus_stop();
        exp_shdn = 1'b1;
        check_state("R8");
        check(code_eff == 6'd0, "R10", code_eff, 0);

        // R4 while shut down: probe with write bit only
        bus_start();
        bus_byte({me, 1'b0}, 1'b0, ka, rd);
        bus_stop();
        check_state("R4");

        // R11: write wakes and loads in the same clock
        do_write(me, 8'h9C, 1'b0, ka, kd);
        exp_code = 8'h9C;
        exp_shdn = 1'b0;
        check(code_eff == 6'h27, "R11", code_eff, 6'h27);
        check_state("R11");

        // R13: short SCL pulse inside a byte is rejected
        do_write(me, 8'hA8, 1'b1, ka, kd);
        exp_code = 8'hA8;
        check(ka && kd, "R13", {ka, kd}, 3);
        check_state("R13");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule